// File: doc/BRIEF.md
# Storage host adapter global register block

This block holds the adapter-wide registers of a multi-port storage host controller and sits on a plain 32-bit register bus. The bus has a word address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the strobe. The block holds five registers:

- capability: fixed size fields plus a few bits that software may write back
- global control: reset, interrupt enable and mode enable
- per-port interrupt status
- writable ports-implemented map
- read-only version word

Each port drives one level-sensitive interrupt request into the block. The block latches each request into a write-1-to-clear status bit, gated by the ports-implemented map. It drives a single interrupt line that is qualified by the global enable.

Software starts a controller reset by writing the reset bit. The block then clears the enables and all pending status. It sends a one-cycle reset pulse to the ports and holds the reset bit set for a fixed, parameterised number of cycles, after which the bit clears itself. For addresses in the port region, the block decodes which port's register window is addressed and the word offset inside that window, so that the port blocks can claim the access.

Top module: `hba_glb_regs`

## Requirements
- R1: Word 0 reads as the capability register and word 4 reads as the version parameter. In the capability register, bits 4:0 = ports−1, bits 12:8 = slots−1, bits 23:20 = speed code and bit 31 = 64-bit support. A read strobe in cycle k puts the value on the read data in cycle k+1; a cycle with no read strobe gives zero read data in the next cycle.
- R2: Only the capability bits selected by the write mask (by default bits 28, 27 and 17) take written data. The other capability bits keep their fixed values.
- R3: Word 1 is global control. Bit 1 is the interrupt enable and bit 31 is the mode enable; a write with bit 0 clear loads both bits.
- R4: A control write with bit 0 set clears the interrupt enable and the mode enable. Control bit 0 then reads 1 for exactly RST_CYCLES cycles and clears itself. Control writes made while the reset runs have no effect.
- R5: The port reset output is high for exactly the one cycle that follows an accepted reset write.
- R6: Word 2 holds one status bit per port, in bit position = port number. A bit sets on every cycle in which its port's request is high and its implemented bit is 1. Writing 1 to a bit clears it and writing 0 leaves it alone; a set in the same cycle wins over the clear. All bits clear on an accepted reset write and stay clear while the reset runs.
- R7: Word 3 is the ports-implemented map, with one bit per port and reset value all ones. It is writable, and a 0 bit blocks its port's request from the status register.
- R8: The interrupt output equals the interrupt enable ANDed with the OR of all status bits.
- R9: For byte addresses at 0x100 and above, the port number is (byte−0x100)/0x80 and the word offset is ((byte−0x100) mod 0x80)/4. The window-hit output is high only when the port number is below the port count. Reads in this region return zero from this block.
- R10: Word offsets 5 to 0x3F read as zero, and writes to them change no register.
- R11: After the synchronous reset, all registers hold their reset values and the interrupt, port reset and read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| port_req | input | NPORTS | Level interrupt request from each port |
| irq | output | 1 | Adapter interrupt |
| port_rst | output | 1 | One-cycle controller reset pulse to the ports |
| win_hit | output | 1 | Address falls in an existing port window |
| win_port | output | PIDX_W | Port number of the addressed window |
| win_off | output | 5 | Word offset inside the port window |

## Verification
The bench builds the block with three ports, eight slots, speed code 2, 64-bit support on and a five-cycle reset. With an odd port count, the window at port number 3 is a decodable address that has no port behind it, so the decoder's bound is exercised. The short reset lets the whole busy interval be observed cycle by cycle, with requests and control writes arriving inside it. Three ports are also enough to mask one port with a 0 in the implemented map while its neighbours still latch, and to clear and set the same bit in a single cycle.

// File: rtl/hba_glb_pkg.sv
package hba_glb_pkg;
  // word offsets of the global registers
  localparam int unsigned W_CAP   = 0;
  localparam int unsigned W_CTL   = 1;
  localparam int unsigned W_ISTAT = 2;
  localparam int unsigned W_PI    = 3;
  localparam int unsigned W_VER   = 4;
  // port windows: byte 0x100 base, byte 0x80 stride
  localparam int unsigned PORT_BASE_W = 64;
  localparam int unsigned WIN_LOG2    = 5;
  // control bit positions
  localparam int unsigned CTL_RST  = 0;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_MODE = 31;

  function automatic logic [31:0] cap_fixed(input int unsigned np, input int unsigned ns,
                                            input int unsigned sp, input bit a64);
    logic [31:0] v;
    v        = '0;
    v[4:0]   = 5'(np - 1);
    v[12:8]  = 5'(ns - 1);
    v[23:20] = 4'(sp);
    v[31]    = a64;
    return v;
  endfunction
endpackage

// File: rtl/hba_rst_seq.sv
module hba_rst_seq #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic port_rst
);
  localparam int unsigned CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      port_rst <= 1'b0;
    end else begin
      port_rst <= start && !busy;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= CW'(RST_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  p_pulse_one_r5: assert property (@(posedge clk) disable iff (rst)
    port_rst |=> !port_rst);
  p_busy_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> busy);
endmodule

// File: rtl/hba_irq_stat.sv
module hba_irq_stat #(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic [NPORTS-1:0] req,
  input  logic [NPORTS-1:0] pi,
  input  logic              w1c_en,
  input  logic [NPORTS-1:0] w1c,
  output logic [NPORTS-1:0] istat
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      istat <= '0;
    end else begin
      for (int i = 0; i < int'(NPORTS); i++) begin
        if (req[i] && pi[i])        istat[i] <= 1'b1;
        else if (w1c_en && w1c[i])  istat[i] <= 1'b0;
      end
    end
  end

  p_clear_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (istat == '0));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && |(req & pi)) |=> ((istat & $past(req & pi)) == $past(req & pi)));
endmodule

// File: rtl/hba_win_dec.sv
module hba_win_dec
  import hba_glb_pkg::*;
#(
  parameter int unsigned AW     = 10,
  parameter int unsigned NPORTS = 4,
  parameter int unsigned PIDX_W = 2
) (
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic [PIDX_W-1:0] port,
  output logic [4:0]        off
);
  localparam int unsigned IW = AW - WIN_LOG2;

  logic [AW-1:0] rel;
  logic [IW-1:0] full_idx;
  logic          above;

  always_comb begin
    above    = addr >= AW'(PORT_BASE_W);
    rel      = addr - AW'(PORT_BASE_W);
    full_idx = rel[AW-1:WIN_LOG2];
    hit      = above && (full_idx < IW'(NPORTS));
    port     = full_idx[PIDX_W-1:0];
    off      = rel[WIN_LOG2-1:0];
  end
endmodule

// File: rtl/hba_glb_regs.sv
module hba_glb_regs
  import hba_glb_pkg::*;
#(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned NSLOTS     = 32,
  parameter int unsigned SPEED_CODE = 1,
  parameter bit          ADDR64     = 1'b1,
  parameter int unsigned RST_CYCLES = 64,
  parameter logic [31:0] VERSION    = 32'h0001_0100,
  parameter logic [31:0] CAP_WMASK  = 32'h1802_0000,
  parameter int unsigned AW         = 10,
  localparam int unsigned PIDX_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [NPORTS-1:0] port_req,
  output logic              irq,
  output logic              port_rst,
  output logic              win_hit,
  output logic [PIDX_W-1:0] win_port,
  output logic [4:0]        win_off
);
  localparam logic [31:0] CAP_FIX = cap_fixed(NPORTS, NSLOTS, SPEED_CODE, ADDR64) & ~CAP_WMASK;

  logic [31:0]       cap_sw;
  logic              ie, mode, busy, start;
  logic [NPORTS-1:0] pi, istat;
  logic              wr_cap, wr_ctl, wr_ist, wr_pi;
  logic [31:0]       rd_mux;

  always_comb begin
    wr_cap = wr_en && (addr == AW'(W_CAP));
    wr_ctl = wr_en && (addr == AW'(W_CTL));
    wr_ist = wr_en && (addr == AW'(W_ISTAT));
    wr_pi  = wr_en && (addr == AW'(W_PI));
    start  = wr_ctl && wr_data[CTL_RST] && !busy;
  end

  hba_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .port_rst(port_rst));

  hba_irq_stat #(.NPORTS(NPORTS)) u_ist (
    .clk(clk), .rst(rst), .clr_all(start || busy), .req(port_req), .pi(pi),
    .w1c_en(wr_ist), .w1c(wr_data[NPORTS-1:0]), .istat(istat));

  hba_win_dec #(.AW(AW), .NPORTS(NPORTS), .PIDX_W(PIDX_W)) u_dec (
    .addr(addr), .hit(win_hit), .port(win_port), .off(win_off));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sw <= '0;
      ie     <= 1'b0;
      mode   <= 1'b0;
      pi     <= '1;
    end else begin
      if (wr_cap) cap_sw <= wr_data & CAP_WMASK;
      if (wr_pi)  pi     <= wr_data[NPORTS-1:0];
      if (wr_ctl && !busy) begin
        if (wr_data[CTL_RST]) begin
          ie   <= 1'b0;
          mode <= 1'b0;
        end else begin
          ie   <= wr_data[CTL_IE];
          mode <= wr_data[CTL_MODE];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(W_CAP))        rd_mux = CAP_FIX | cap_sw;
    else if (addr == AW'(W_CTL)) begin
      rd_mux[CTL_RST]  = busy;
      rd_mux[CTL_IE]   = ie;
      rd_mux[CTL_MODE] = mode;
    end
    else if (addr == AW'(W_ISTAT)) rd_mux = 32'(istat);
    else if (addr == AW'(W_PI))    rd_mux = 32'(pi);
    else if (addr == AW'(W_VER))   rd_mux = VERSION;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? rd_mux : '0;
  end

  assign irq = ie && (|istat);

  p_en_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> (!ie && !mode));
  p_busy_blocks_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !port_rst) |=> ($stable(ie) && $stable(mode)));
  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie);
  p_rd_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  p_window_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && win_hit) |=> (rd_data == '0));
endmodule

// File: tb/sim_hba_glb_regs.sv
module sim_hba_glb_regs;
  localparam int NP = 3;
  localparam int RC = 5;
  localparam logic [31:0] VER   = 32'h0001_0100;
  localparam logic [31:0] WMASK = 32'h1802_0000;
  localparam logic [31:0] CAPF  = 32'h8020_0702;

  logic          clk = 0;
  logic          rst = 1;
  logic [9:0]    addr = '0;
  logic          wr_en = 0, rd_en = 0;
  logic [31:0]   wr_data = '0;
  logic [NP-1:0] port_req = '0;
  logic [31:0]   rd_data;
  logic          irq, port_rst, win_hit;
  logic [1:0]    win_port;
  logic [4:0]    win_off;

  int checks = 0;
  int errors = 0;

  hba_glb_regs #(.NPORTS(NP), .NSLOTS(8), .SPEED_CODE(2), .ADDR64(1'b1),
    .RST_CYCLES(RC), .VERSION(VER), .CAP_WMASK(WMASK), .AW(10)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .port_req(port_req), .irq(irq),
    .port_rst(port_rst), .win_hit(win_hit), .win_port(win_port), .win_off(win_off));

  always #2 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_capw = '0;
  bit          m_ie = 0, m_mode = 0, m_busy = 0, m_prst = 0;
  int          m_cnt = 0;
  logic [2:0]  m_pi = 3'b111, m_ist = '0;
  logic [31:0] m_rd = '0;
  string       m_rtag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input int a);
    case (a)
      0: return CAPF | m_capw;
      1: return {m_mode, 29'b0, m_ie, m_busy};
      2: return {29'b0, m_ist};
      3: return {29'b0, m_pi};
      4: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input int a, input bit we, input logic [31:0] wd,
                      input bit re, input logic [2:0] rq);
    int  byte_a, idx;
    bit  start, exp_hit;
    logic [2:0] nist;
    addr = 10'(a); wr_en = we; wr_data = wd; rd_en = re; port_req = rq;
    #1;
    chk(m_rtag, rd_data, m_rd);
    chk("R8", 32'(irq), 32'(m_ie && (m_ist != 0)));
    chk("R5", 32'(port_rst), 32'(m_prst));
    byte_a  = a * 4;
    idx     = (byte_a - 256) / 128;
    exp_hit = (byte_a >= 256) && (idx < NP);
    chk("R9", 32'(win_hit), 32'(exp_hit));
    if (exp_hit) begin
      chk("R9", 32'(win_port), 32'(idx));
      chk("R9", 32'(win_off), 32'(((byte_a - 256) % 128) / 4));
    end
    @(posedge clk);
    start = we && a == 1 && wd[0] && !m_busy;
    // read path
    m_rd = re ? mread(a) : 32'h0;
    if (a == 0)      m_rtag = (wd != 0) ? "R2" : "R1";
    else if (a == 1) m_rtag = m_busy ? "R4" : "R3";
    else if (a == 2) m_rtag = "R6";
    else if (a == 3) m_rtag = "R7";
    else if (a == 4) m_rtag = "R1";
    else if (a < 64) m_rtag = "R10";
    else             m_rtag = "R9";
    // status
    if (start || m_busy) nist = '0;
    else begin
      nist = m_ist;
      if (we && a == 2) nist = nist & ~wd[2:0];
      nist = nist | (rq & m_pi);
    end
    m_ist = nist;
    m_prst = start;
    if (we && a == 1 && !m_busy) begin
      if (wd[0]) begin m_ie = 0; m_mode = 0; end
      else begin m_ie = wd[1]; m_mode = wd[31]; end
    end
    if (start) begin m_busy = 1; m_cnt = RC - 1; end
    else if (m_busy) begin
      if (m_cnt == 0) m_busy = 0; else m_cnt--;
    end
    if (we && a == 3) m_pi = wd[2:0];
    if (we && a == 0) m_capw = wd & WMASK;
    @(negedge clk);
  endtask

  task automatic rd(input int a);
    step(a, 0, 32'h0, 1, 3'b000);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(a, 1, d, 0, 3'b000);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11: outputs after reset
    chk("R11", rd_data, 32'h0);
    chk("R11", 32'(irq), 32'h0);
    chk("R11", 32'(port_rst), 32'h0);
    @(negedge clk);
    // R1, R11: reset values of every global word
    for (int a = 0; a < 5; a++) rd(a);
    rd(5); rd(63); step(0, 0, 0, 0, 0);
    // R2: only masked capability bits are writable
    wr(0, 32'hFFFF_FFFF); rd(0); wr(0, 32'h0000_0000); rd(0);
    wr(0, 32'h0802_00FF); rd(0);
    // R3: enables
    wr(1, 32'h8000_0002); rd(1);
    wr(1, 32'h0000_0002); rd(1);
    // R6, R8: latch, hold after request drops
    step(2, 0, 0, 0, 3'b010); rd(2); rd(2);
    wr(2, 32'h0); rd(2);
    wr(2, 32'h2); rd(2);
    step(2, 1, 32'h7, 0, 3'b001); rd(2);
    wr(2, 32'h7); rd(2);
    // R7: mask a port
    wr(3, 32'hFFFF_FFFD); rd(3);
    step(2, 0, 0, 1, 3'b111); rd(2);
    step(2, 0, 0, 1, 3'b010); rd(2);
    // R8: enable off leaves status but drops irq
    wr(1, 32'h0); rd(2); wr(1, 32'h2); rd(1);
    // R10: undefined words
    for (int a = 5; a < 64; a += 9) wr(a, 32'hFFFF_FFFF);
    for (int a = 0; a < 5; a++) rd(a);
    rd(17);
    // R4, R5, R6: controller reset
    wr(1, 32'h8000_0002);
    step(1, 1, 32'h8000_0003, 0, 3'b111);
    for (int c = 0; c < RC + 2; c++) begin
      if (c == 1) step(1, 1, 32'h8000_0002, 1, 3'b111);
      else if (c == 2) step(1, 1, 32'h0000_0001, 1, 3'b101);
      else step(1, 0, 0, 1, 3'b000);
    end
    rd(2); rd(3);
    wr(1, 32'h0000_0002); rd(1);
    step(2, 0, 0, 0, 3'b100); rd(2);
    // R9: window decode and reads there
    for (int a = 64; a < 1024; a += 31) rd(a);
    rd(64); rd(95); rd(96); rd(159); rd(160); rd(191); rd(1023);
    wr(64, 32'hFFFF_FFFF); wr(160, 32'hFFFF_FFFF);
    for (int a = 0; a < 5; a++) rd(a);
    step(0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule